// File: doc/BRIEF.md
# Configurable Event Trigger Channel

This block is one channel of an event request unit. It watches two groups of candidate event lines, picks one line from each group for its two paths, and combines the two picked lines into a single event signal. Either path may be inverted first, and the merge may take path A alone, path B alone, their OR, or their AND. Those choices cover twelve distinct logic functions. The channel compares the merged signal with its value on the previous clock. When a change matches the enabled edge kinds, it updates a status flag and may send a one-cycle trigger pulse to one of four output gating channels.

Software configures the channel through a small write port with two registers. The selection register is shared by several channels, and each channel decodes only its own nibble. The control register holds the merge function, the edge enables, the flag mode, the pulse enable and the destination. A strobe bit in the control register clears the flag. The candidate lines are expected to be synchronous to `clk` already.

Top module: `evtrig_channel`

## Requirements
- R1: A write to address 0 loads this channel's selection from bits [4*CHAN_IDX+3:4*CHAN_IDX] of the data. The low 2 bits of that nibble pick `cand_a[sel]` for path A, and the upper 2 bits pick `cand_b[sel]` for path B. Bits of other nibbles have no effect.
- R2: Control bits [1:0] choose the merge: 0 = A', 1 = B', 2 = A' OR B', 3 = A' AND B'. Here A' is path A XOR control bit 2 and B' is path B XOR control bit 3.
- R3: Control bit 4 enables detection of a rising change (0 to 1) of the merged signal, and control bit 5 enables detection of a falling change. With a kind of change disabled, that change makes no pulse and leaves the flag alone.
- R4: An input change sampled at clock edge k drives the trigger pulse high for exactly the one cycle after edge k.
- R5: With control bit 6 clear (software mode), any detected edge sets the flag and the flag stays set until a write to address 1 with bit 12 set. An edge in the same cycle as that clear write wins, and the flag stays set.
- R6: With control bit 6 set (hardware mode), a detected rising edge sets the flag and a detected falling edge clears it.
- R7: Control bit 7 enables pulses. Control bits [9:8] select which `trig_o` bit carries the pulse, and no other bit is ever driven.
- R8: With the pulse enable clear, detected edges still update the flag while `trig_o` stays zero.
- R9: After reset all configuration is zero, the flag and `trig_o` are zero, and the stored previous merged value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = selection register, 1 = control register |
| wr_data | input | 32 | Write data |
| cand_a | input | 4 | Candidate lines for path A |
| cand_b | input | 4 | Candidate lines for path B |
| trig_o | output | 4 | One-cycle trigger pulses, one per gating channel |
| flag_o | output | 1 | Channel status flag |

## Verification
A stale or corrupted previous-value register shows up one cycle after the next input change. It appears as a pulse where none was due, or a missing pulse, and as a flag that moves the wrong way. A wrong merge function or path selection is caught by walking every input pattern under all sixteen control codes in hardware flag mode. In that mode the flag follows the merged signal, so an error is visible on `flag_o` in the following cycle. Routing errors appear as a pulse on the wrong `trig_o` bit in the very cycle the pulse is due.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

    parameter int unsigned CAND_N  = 4;
    parameter int unsigned DEST_N  = 4;
    parameter int unsigned REG_W   = 32;
    parameter int unsigned ADDR_W  = 1;

    localparam int unsigned SEL_W   = $clog2(CAND_N);
    localparam int unsigned DEST_W  = $clog2(DEST_N);
    localparam int unsigned NIB_W   = 2 * SEL_W;
    localparam int unsigned CLR_BIT = 12;

    localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);

    typedef enum logic [1:0] {
        OP_PATH_A = 2'd0,
        OP_PATH_B = 2'd1,
        OP_EITHER = 2'd2,
        OP_BOTH   = 2'd3
    } merge_op_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              pulse_en;
        logic              hw_flag;
        logic              fall_en;
        logic              rise_en;
        logic              inv_b;
        logic              inv_a;
        merge_op_e         op;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
    } sel_t;

    function automatic logic merge_paths(input ctrl_t c, input logic a, input logic b);
        logic x;
        logic y;
        logic r;
        x = a ^ c.inv_a;
        y = b ^ c.inv_b;
        case (c.op)
            OP_PATH_A: r = x;
            OP_PATH_B: r = y;
            OP_EITHER: r = x | y;
            default:   r = x & y;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evtrig_cfg.sv
module evtrig_cfg
    import evtrig_pkg::*;
#(
    parameter int unsigned CHAN_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output sel_t              sel_o,
    output ctrl_t             ctrl_o,
    output logic              clr_o
);

    localparam int unsigned NIB_LSB = CHAN_IDX * NIB_W;

    sel_t  sel_q;
    ctrl_t ctrl_q;
    logic  hit_sel;
    logic  hit_ctrl;
    logic  unused_bits;

    assign hit_sel  = wr_en && (wr_addr == ADDR_SEL);
    assign hit_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (hit_sel)
                sel_q <= sel_t'(wr_data[NIB_LSB +: NIB_W]);
            if (hit_ctrl)
                ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign clr_o       = hit_ctrl && wr_data[CLR_BIT];
    assign sel_o       = sel_q;
    assign ctrl_o      = ctrl_q;
    assign unused_bits = ^wr_data;

    // R1: only this channel's nibble reaches the selection
    a_r1_own_nibble: assert property (@(posedge clk) disable iff (rst)
        hit_sel |=> (sel_q == $past(wr_data[NIB_LSB +: NIB_W])));

    // R1: writes to the other address leave the selection unchanged
    a_r1_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !hit_sel |=> $stable(sel_q));

endmodule

// File: rtl/evtrig_path_sel.sv
module evtrig_path_sel
    import evtrig_pkg::*;
(
    input  logic [CAND_N-1:0] cand_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              line_o
);

    assign line_o = cand_i[sel_i];

endmodule

// File: rtl/evtrig_edge.sv
module evtrig_edge
    import evtrig_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl_i,
    input  logic  path_a,
    input  logic  path_b,
    input  logic  clr_i,
    output logic  evt_o,
    output logic  flag_o
);

    logic cur;
    logic prev_q;
    logic flag_q;
    logic rise_hit;
    logic fall_hit;
    logic flag_d;
    logic unused_fields;

    assign cur      = merge_paths(ctrl_i, path_a, path_b);
    assign rise_hit = ctrl_i.rise_en &&  cur && !prev_q;
    assign fall_hit = ctrl_i.fall_en && !cur &&  prev_q;
    assign evt_o    = rise_hit || fall_hit;

    always_comb begin
        flag_d = flag_q;
        if (ctrl_i.hw_flag) begin
            if (rise_hit)
                flag_d = 1'b1;
            else if (fall_hit)
                flag_d = 1'b0;
            else if (clr_i)
                flag_d = 1'b0;
        end else begin
            if (evt_o)
                flag_d = 1'b1;
            else if (clr_i)
                flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= cur;
            flag_q <= flag_d;
        end
    end

    assign flag_o        = flag_q;
    assign unused_fields = ^{ctrl_i.dest, ctrl_i.pulse_en};

    // R3: the flag can only rise after the merged signal changed
    a_r3_flag_needs_change: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(cur != prev_q));

    // R5: in software mode the flag holds until cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.hw_flag && flag_q && !clr_i) |=> flag_q);

    // R6: in hardware mode an enabled falling change clears the flag
    a_r6_hw_fall: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.hw_flag && ctrl_i.fall_en && prev_q && !cur) |=> !flag_q);

endmodule

// File: rtl/evtrig_route.sv
module evtrig_route
    import evtrig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_i,
    input  logic              pulse_en,
    input  logic [DEST_W-1:0] dest_i,
    output logic [DEST_N-1:0] trig_o
);

    logic [DEST_N-1:0] trig_q;

    for (genvar i = 0; i < DEST_N; i++) begin : g_dest
        always_ff @(posedge clk) begin
            if (rst)
                trig_q[i] <= 1'b0;
            else
                trig_q[i] <= evt_i && pulse_en && (dest_i == DEST_W'(i));
        end
    end

    assign trig_o = trig_q;

    // R7: at most one destination pulses at a time
    a_r7_one_dest: assert property (@(posedge clk) disable iff (rst)
        $onehot0(trig_q));

    // R4: a pulse always follows a detected event one cycle earlier
    a_r4_pulse_after_evt: assert property (@(posedge clk) disable iff (rst)
        (|trig_q) |-> $past(evt_i));

endmodule

// File: rtl/evtrig_channel.sv
module evtrig_channel
    import evtrig_pkg::*;
#(
    parameter int unsigned CHAN_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [CAND_N-1:0] cand_a,
    input  logic [CAND_N-1:0] cand_b,
    output logic [DEST_N-1:0] trig_o,
    output logic              flag_o
);

    sel_t  sel;
    ctrl_t ctrl;
    logic  clr;
    logic  line_a;
    logic  line_b;
    logic  evt;

    evtrig_cfg #(.CHAN_IDX(CHAN_IDX)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_o   (sel),
        .ctrl_o  (ctrl),
        .clr_o   (clr)
    );

    evtrig_path_sel u_sel_a (
        .cand_i (cand_a),
        .sel_i  (sel.sel_a),
        .line_o (line_a)
    );

    evtrig_path_sel u_sel_b (
        .cand_i (cand_b),
        .sel_i  (sel.sel_b),
        .line_o (line_b)
    );

    evtrig_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .path_a (line_a),
        .path_b (line_b),
        .clr_i  (clr),
        .evt_o  (evt),
        .flag_o (flag_o)
    );

    evtrig_route u_route (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .pulse_en (ctrl.pulse_en),
        .dest_i   (ctrl.dest),
        .trig_o   (trig_o)
    );

    // R7: no pulse unless the enable was set when the edge was seen
    a_r7_pulse_gated: assert property (@(posedge clk) disable iff (rst)
        (|trig_o) |-> $past(ctrl.pulse_en));

    // R9: outputs are quiet right after a reset cycle
    a_r9_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> ((trig_o == '0) && !flag_o));

endmodule

// File: tb/sim_evtrig_channel.sv
`timescale 1ns/1ps
module sim_evtrig_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  cand_a = '0;
    logic [3:0]  cand_b = '0;
    logic [3:0]  trig_o;
    logic        flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evtrig_channel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cand_a(cand_a), .cand_b(cand_b), .trig_o(trig_o), .flag_o(flag_o)
    );

    localparam logic [31:0] CLR = 32'h1000;

    function automatic logic [31:0] mk(int op, bit ia, bit ib, bit re, bit fe,
                                       bit hw, bit pe, int dest);
        logic [31:0] v;
        v = '0;
        v[1:0] = 2'(op);
        v[2] = ia; v[3] = ib; v[4] = re; v[5] = fe;
        v[6] = hw; v[7] = pe;
        v[9:8] = 2'(dest);
        return v;
    endfunction

    function automatic bit model(int op, bit ia, bit ib, bit a, bit b);
        bit x;
        bit y;
        x = a ^ ia;
        y = b ^ ib;
        case (op)
            0: return x;
            1: return y;
            2: return x | y;
            default: return x & y;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [0:0] addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic drive(input logic [3:0] a, input logic [3:0] b);
        cand_a = a; cand_b = b;
        @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] selw, input logic [31:0] ctrlw);
        wr(1'b0, selw);
        wr(1'b1, ctrlw);
        repeat (2) @(negedge clk);
        wr(1'b1, ctrlw | CLR);
    endtask

    task automatic t_reset;
        chk(trig_o == 4'h0, "R9 trig after reset", trig_o, 0);
        chk(flag_o == 1'b0, "R9 flag after reset", flag_o, 0);
        drive(4'hF, 4'hF);
        chk(trig_o == 4'h0, "R9 zero config gives no pulse", trig_o, 0);
        drive(4'h0, 4'h0);
        chk(flag_o == 1'b0, "R9 zero config leaves flag", flag_o, 0);
    endtask

    task automatic t_select;
        setup(32'hFFFF_FF6F, mk(0, 0, 0, 1, 1, 0, 1, 0));
        drive(4'b0001, 4'h0);
        chk(trig_o == 4'h0, "R1 unselected A line ignored", trig_o, 0);
        drive(4'b0101, 4'h0);
        chk(trig_o == 4'b0001, "R1 A picks line 2", trig_o, 1);
        @(negedge clk);
        wr(1'b0, 32'h0000_0060);
        drive(4'b0001, 4'h0);
        chk(trig_o == 4'b0001, "R1 other nibbles ignored", trig_o, 1);
        setup(32'h0000_0060, mk(1, 0, 0, 1, 1, 0, 1, 0));
        drive(4'h0, 4'b0001);
        chk(trig_o == 4'h0, "R1 unselected B line ignored", trig_o, 0);
        drive(4'h0, 4'b0011);
        chk(trig_o == 4'b0001, "R1 B picks line 1", trig_o, 1);
        @(negedge clk);
    endtask

    task automatic t_func;
        bit pa[4] = '{0, 1, 1, 0};
        bit pb[4] = '{0, 0, 1, 1};
        wr(1'b0, 32'h0);
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                bit ia;
                bit ib;
                bit za;
                bit zb;
                ia = k[0]; ib = k[1];
                za = 0; zb = 0;
                for (int p = 3; p >= 0; p--)
                    if (!model(op, ia, ib, pa[p], pb[p])) begin za = pa[p]; zb = pb[p]; end
                drive({3'b0, za}, {3'b0, zb});
                wr(1'b1, mk(op, ia, ib, 0, 0, 1, 0, 0) | CLR);
                @(negedge clk);
                wr(1'b1, mk(op, ia, ib, 1, 1, 1, 0, 0));
                for (int p = 0; p < 4; p++) begin
                    bit e;
                    drive({3'b0, pa[p]}, {3'b0, pb[p]});
                    e = model(op, ia, ib, pa[p], pb[p]);
                    chk(flag_o == e, $sformatf("R2 op=%0d ia=%0d ib=%0d a=%0d b=%0d",
                        op, ia, ib, pa[p], pb[p]), flag_o, e);
                end
            end
        end
        drive(4'h0, 4'h0);
    endtask

    task automatic t_edges;
        setup(32'h0, mk(0, 0, 0, 1, 0, 0, 1, 2));
        drive(4'h1, 4'h0);
        chk(trig_o == 4'b0100, "R4 pulse one cycle after rising", trig_o, 4);
        chk(flag_o == 1'b1, "R3 rising sets flag", flag_o, 1);
        @(negedge clk);
        chk(trig_o == 4'h0, "R4 pulse lasts one cycle", trig_o, 0);
        drive(4'h0, 4'h0);
        chk(trig_o == 4'h0, "R3 falling ignored when disabled", trig_o, 0);
        setup(32'h0, mk(0, 0, 0, 0, 1, 0, 1, 2));
        drive(4'h1, 4'h0);
        chk(trig_o == 4'h0, "R3 rising ignored when disabled", trig_o, 0);
        chk(flag_o == 1'b0, "R3 flag untouched by disabled edge", flag_o, 0);
        drive(4'h0, 4'h0);
        chk(trig_o == 4'b0100, "R3 falling detected", trig_o, 4);
        setup(32'h0, mk(0, 0, 0, 0, 0, 0, 1, 2));
        drive(4'h1, 4'h0);
        chk(trig_o == 4'h0, "R3 detection off rising", trig_o, 0);
        drive(4'h0, 4'h0);
        chk(trig_o == 4'h0, "R3 detection off falling", trig_o, 0);
        chk(flag_o == 1'b0, "R3 detection off flag", flag_o, 0);
    endtask

    task automatic t_sw_flag;
        setup(32'h0, mk(0, 0, 0, 1, 1, 0, 0, 0));
        drive(4'h1, 4'h0);
        chk(flag_o == 1'b1, "R5 edge sets flag", flag_o, 1);
        drive(4'h0, 4'h0);
        chk(flag_o == 1'b1, "R5 flag sticky on falling", flag_o, 1);
        wr(1'b1, mk(0, 0, 0, 1, 1, 0, 0, 0) | CLR);
        chk(flag_o == 1'b0, "R5 software clear", flag_o, 0);
        cand_a = 4'h1;
        wr(1'b1, mk(0, 0, 0, 1, 1, 0, 0, 0) | CLR);
        chk(flag_o == 1'b1, "R5 edge wins over clear", flag_o, 1);
        wr(1'b1, mk(0, 0, 0, 1, 1, 0, 0, 0) | CLR);
        chk(flag_o == 1'b0, "R5 clear after collision", flag_o, 0);
        drive(4'h0, 4'h0);
    endtask

    task automatic t_hw_flag;
        setup(32'h0, mk(0, 0, 0, 1, 1, 1, 0, 0));
        drive(4'h1, 4'h0);
        chk(flag_o == 1'b1, "R6 rising sets flag", flag_o, 1);
        drive(4'h0, 4'h0);
        chk(flag_o == 1'b0, "R6 falling clears flag", flag_o, 0);
        setup(32'h0, mk(0, 0, 0, 1, 0, 1, 0, 0));
        drive(4'h1, 4'h0);
        chk(flag_o == 1'b1, "R6 rising only sets", flag_o, 1);
        drive(4'h0, 4'h0);
        chk(flag_o == 1'b1, "R6 disabled falling keeps flag", flag_o, 1);
    endtask

    task automatic t_route;
        setup(32'h0, mk(0, 0, 0, 1, 1, 0, 0, 3));
        drive(4'h1, 4'h0);
        chk(trig_o == 4'h0, "R8 no pulse when disabled", trig_o, 0);
        chk(flag_o == 1'b1, "R8 flag still updates", flag_o, 1);
        setup(32'h0, mk(0, 0, 0, 1, 1, 0, 1, 3));
        drive(4'h0, 4'h0);
        chk(trig_o == 4'b1000, "R7 route to channel 3", trig_o, 8);
        @(negedge clk);
        setup(32'h0, mk(0, 0, 0, 1, 1, 0, 1, 1));
        drive(4'h1, 4'h0);
        chk(trig_o == 4'b0010, "R7 route to channel 1", trig_o, 2);
        chk($countones(trig_o) == 1, "R7 single destination", $countones(trig_o), 1);
        drive(4'h0, 4'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select();
        t_func();
        t_edges();
        t_sw_flag();
        t_hw_flag();
        t_route();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule